// File: doc/BRIEF.md
# Serial Memory Read Target

This block is the target side of a four-wire serial link. It answers the read path of a small byte-wide memory. A single system clock runs at least eight times faster than the serial clock. It samples the serial clock, the serial data input and the active-low select through two-stage synchronisers, then finds the serial clock edges in its own domain. Every transaction starts when the select goes low. The first byte shifted in is a command. If the command is the read opcode, the next two bytes form a start address. The block then returns one memory byte after another, most significant bit first. It steps the address by one for each byte and keeps going until the select is raised.

Data in is taken on the rising serial clock edge and data out changes on the falling edge, whatever level the clock rests at between transactions. The output has a separate enable for the pad driver. The enable is low whenever the select is high, so the line can be shared. The memory content is fixed at build time and computed from the entry index. Entry i holds (7*i + 60) mod 256. The array is indexed by the low address bits, so the content repeats every 64 addresses in the default build.

Top module: `spi_rd_target`

## Requirements
- R1: While cs_n has been high for three or more system clocks (and out of reset), miso_oe is 0 and miso is 0.
- R2: Once cs_n has been low for three or more system clocks, miso_oe is 1.
- R3: While the command byte and the two address bytes are being shifted in, every bit seen on miso before a rising SCK edge is 0.
- R4: Command byte 8'h03 followed by a 16-bit address sent high byte first makes the block return, from the next byte on, the content at that address: value (7*(A mod 64) + 60) mod 256, most significant bit first.
- R5: Each further byte clocked after the address comes from the next address (A+1, A+2, ...), with no limit on the count while cs_n stays low.
- R6: The address wraps from 16'hFFFF to 16'h0000 while streaming.
- R7: Any command byte other than 8'h03 leaves miso at 0 for all remaining bits of that transaction.
- R8: Raising cs_n at any bit position aborts the transaction, and the next transaction again starts with a command byte.
- R9: Mode with SCK idling high (first edge falling) gives the same data as mode with SCK idling low, since sampling is always on the rising edge and output changes on the falling edge.
- R10: SCK and MOSI activity while cs_n is high has no effect: miso_oe stays 0, miso stays 0, and the next transaction reads correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the controller, asynchronous |
| mosi | input | 1 | Serial data from the controller, sampled on rising SCK |
| cs_n | input | 1 | Active-low select; high ends any transaction |
| miso | output | 1 | Serial data to the controller, changes on falling SCK |
| miso_oe | output | 1 | Output enable for the miso pad driver |

## Verification
The bench sweeps start addresses spread across the whole 16-bit space in both SCK idle levels. A block that sampled on the wrong edge, or keyed its behaviour on the first edge, would return shifted bits in one of the two modes. A long stream that runs past the array size, plus a start just below 16'hFFFF, covers two faults: an address that stops advancing, and one that fails to wrap. A wrong command, an abort in the middle of the address, and SCK toggling while deselected are all followed by a clean read. A design that kept stale bit counts or state after the select rose would return misaligned data there, and one that drove during those phases would show nonzero bits or a raised enable.

// File: rtl/spi_rd_pkg.sv
// Shared types and constants for the serial memory read target.
package spi_rd_pkg;
    // Transaction phases of the target.
    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } rd_state_e;

    // Command byte that selects the streaming read.
    localparam logic [7:0] OP_READ = 8'h03;
endpackage

// File: rtl/spi_rd_sync.sv
// Two-flop synchroniser bank with edge detection for slow asynchronous inputs.
// Assumes each input stays stable for several system clocks between changes.
module spi_rd_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Synchronise the inputs and keep one delayed copy for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
            prev_q <= RST_VAL;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
    assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/spi_rd_mem.sv
// Read-only byte array with build-time content: entry i = FILL_MUL*i + FILL_ADD.
// Combinational read; index width MEM_AW.
module spi_rd_mem #(
    parameter int MEM_AW   = 6,
    parameter int FILL_MUL = 7,
    parameter int FILL_ADD = 60
) (
    input  logic [MEM_AW-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] rom [DEPTH];

    // Fill each entry with its computed constant.
    for (genvar g = 0; g < DEPTH; g++) begin : g_fill
        assign rom[g] = 8'((g * FILL_MUL + FILL_ADD) % 256);
    end

    assign rd_data_o = rom[rd_addr_i];
endmodule

// File: rtl/spi_rd_ctrl.sv
// Transaction engine: command, address, then endless data stream.
// Assumes synchronised inputs and single-cycle SCK edge strobes; an inactive
// select clears all transaction state.
module spi_rd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              mosi_i,
    input  logic [7:0]        rd_data_i,
    output logic [MEM_AW-1:0] rd_addr_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output rd_state_e         st_o,
    output logic [2:0]        bit_cnt_o,
    output logic              byte_done_o,
    output logic [ADDR_W-1:0] addr_ptr_o
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ACNT_W     = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BYTES - 1);

    rd_state_e         st_q;
    logic [2:0]        bit_cnt_q;
    logic [7:0]        rx_q;
    logic [ADDR_W-1:0] addr_sh_q;
    logic [ACNT_W-1:0] acnt_q;
    logic [ADDR_W-1:0] addr_ptr_q;
    logic [7:0]        tx_q;
    logic              miso_q;
    logic              oe_q;

    logic [7:0]        rx_next;
    logic              byte_done;
    logic [ADDR_W-1:0] rd_addr;

    // Next receive byte, byte boundary and the address to fetch.
    always_comb begin
        rx_next   = {rx_q[6:0], mosi_i};
        byte_done = cs_act_i && sck_rise_i && (bit_cnt_q == 3'd7);
        rd_addr   = (st_q == ST_ADDR) ? {addr_sh_q[ADDR_W-9:0], rx_next} : addr_ptr_q;
    end

    // Output enable follows the synchronised select.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= cs_act_i;
    end

    // Phase sequencing, shifting in on rising SCK and out on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act_i) begin
            st_q       <= ST_CMD;
            bit_cnt_q  <= '0;
            rx_q       <= '0;
            addr_sh_q  <= '0;
            acnt_q     <= '0;
            addr_ptr_q <= '0;
            tx_q       <= '0;
            miso_q     <= 1'b0;
        end else begin
            if (sck_rise_i) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
                rx_q      <= rx_next;
                if (byte_done) begin
                    unique case (st_q)
                        ST_CMD:  st_q <= (rx_next == OP_READ) ? ST_ADDR : ST_SKIP;
                        ST_ADDR: begin
                            addr_sh_q <= rd_addr;
                            if (acnt_q == ACNT_LAST) begin
                                st_q       <= ST_DATA;
                                tx_q       <= rd_data_i;
                                addr_ptr_q <= rd_addr + ADDR_W'(1);
                            end else begin
                                acnt_q <= acnt_q + ACNT_W'(1);
                            end
                        end
                        ST_DATA: begin
                            tx_q       <= rd_data_i;
                            addr_ptr_q <= addr_ptr_q + ADDR_W'(1);
                        end
                        default: st_q <= ST_SKIP;
                    endcase
                end
            end
            if (sck_fall_i) begin
                miso_q <= (st_q == ST_DATA) ? tx_q[3'd7 - bit_cnt_q] : 1'b0;
            end
        end
    end

    assign rd_addr_o   = rd_addr[MEM_AW-1:0];
    assign miso_o      = miso_q & oe_q;
    assign miso_oe_o   = oe_q;
    assign st_o        = st_q;
    assign bit_cnt_o   = bit_cnt_q;
    assign byte_done_o = byte_done;
    assign addr_ptr_o  = addr_ptr_q;
endmodule

// File: rtl/spi_rd_target.sv
// Serial memory read target top: synchronisers, transaction engine, array.
// Assumes clk runs at least 8x the SCK rate; SCK idle level is irrelevant.
module spi_rd_target
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int MEM_AW   = 6,
    parameter int FILL_MUL = 7,
    parameter int FILL_ADD = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic mosi,
    input  logic cs_n,
    output logic miso,
    output logic miso_oe
);
    localparam int SYNC_W = 3;
    localparam int B_SCK  = 0;
    localparam int B_MOSI = 1;
    localparam int B_CS   = 2;

    logic [SYNC_W-1:0] lvl;
    logic [SYNC_W-1:0] rise;
    logic [SYNC_W-1:0] fall;
    logic              cs_act;
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;
    rd_state_e         st_w;
    logic [2:0]        bit_cnt_w;
    logic              byte_done_w;
    logic [ADDR_W-1:0] addr_ptr_w;
    logic              unused_edges;

    spi_rd_sync #(
        .W       (SYNC_W),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, mosi, sck}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    assign cs_act       = ~lvl[B_CS];
    assign unused_edges = ^{rise[B_CS], rise[B_MOSI], fall[B_CS], fall[B_MOSI], lvl[B_SCK]};

    spi_rd_ctrl #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act_i    (cs_act),
        .sck_rise_i  (rise[B_SCK]),
        .sck_fall_i  (fall[B_SCK]),
        .mosi_i      (lvl[B_MOSI]),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .st_o        (st_w),
        .bit_cnt_o   (bit_cnt_w),
        .byte_done_o (byte_done_w),
        .addr_ptr_o  (addr_ptr_w)
    );

    spi_rd_mem #(
        .MEM_AW   (MEM_AW),
        .FILL_MUL (FILL_MUL),
        .FILL_ADD (FILL_ADD)
    ) mem_i (
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );
endmodule

// File: rtl/spi_rd_target_chk.sv
// Property checker for the serial memory read target, bound to the top.
// Relates the select pin, output pins and engine state over time.
module spi_rd_target_chk
    import spi_rd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              miso,
    input logic              miso_oe,
    input logic              cs_act,
    input rd_state_e         st,
    input logic [2:0]        bit_cnt,
    input logic              byte_done,
    input logic [ADDR_W-1:0] addr_ptr
);
    // R1: deselected long enough means output released and quiet.
    assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!miso_oe && !miso));

    // R2: selected long enough means output driven.
    assert_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && !$past(cs_n, 2) && !$past(cs_n, 3)) |-> miso_oe);

    // R3: header phases keep the line low.
    assert_header_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD || st == ST_ADDR) |-> !miso);

    // R5: each streamed byte advances the address by one (wraps per R6).
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && st == ST_DATA) |=> (addr_ptr == $past(addr_ptr) + ADDR_W'(1)));

    // R7: an unknown command keeps the line low.
    assert_skip_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !miso);

    // R8: deselect returns the engine to the command phase at bit zero.
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (st == ST_CMD && bit_cnt == 3'd0));
endmodule

bind spi_rd_target spi_rd_target_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .cs_act    (cs_act),
    .st        (st_w),
    .bit_cnt   (bit_cnt_w),
    .byte_done (byte_done_w),
    .addr_ptr  (addr_ptr_w)
);

// File: tb/spi_rd_target_tb_top.sv
// Self-checking bench for the serial memory read target.
module spi_rd_target_tb_top;
    localparam int H = 8;   // system clocks per SCK half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic cs_n = 1'b1;
    logic miso;
    logic miso_oe;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    spi_rd_target dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .mosi    (mosi),
        .cs_n    (cs_n),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        int idx = int'(a) % 64;
        return 8'((idx * 7 + 60) % 256);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bit: output changes on falling SCK, sample just before rising SCK.
    task automatic xbit(input bit m3, input bit o, output bit i);
        if (m3) sck = 1'b0;
        mosi = o;
        wait_clk(H);
        i = miso;
        sck = 1'b1;
        wait_clk(H);
        if (!m3) sck = 1'b0;
    endtask

    task automatic xbyte(input bit m3, input logic [7:0] o, output logic [7:0] i);
        bit b;
        for (int k = 7; k >= 0; k--) begin
            xbit(m3, o[k], b);
            i[k] = b;
        end
    endtask

    task automatic sel(input bit m3);
        sck = m3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic desel(input bit m3);
        wait_clk(H);
        cs_n = 1'b1;
        sck = m3;
        wait_clk(6);
    endtask

    task automatic do_read(input bit m3, input logic [15:0] addr, input int n, input string tag);
        logic [7:0] r;
        logic [7:0] hdr;
        sel(m3);
        xbyte(m3, 8'h03, r);        hdr = r;
        xbyte(m3, addr[15:8], r);   hdr |= r;
        xbyte(m3, addr[7:0], r);    hdr |= r;
        check8("R3", hdr, 8'h00);
        for (int k = 0; k < n; k++) begin
            xbyte(m3, 8'(k * 37 + 1), r);
            check8(tag, r, exp_byte(addr + 16'(k)));
        end
        desel(m3);
    endtask

    task automatic do_other(input bit m3, input logic [7:0] cmd);
        logic [7:0] r;
        logic [7:0] acc;
        sel(m3);
        xbyte(m3, cmd, r);
        acc = r;
        for (int k = 0; k < 4; k++) begin
            xbyte(m3, 8'hFF, r);
            acc |= r;
        end
        check8("R7", acc, 8'h00);
        desel(m3);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        bit b;
        int bad;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state, output released.
        check8("R1", {6'd0, miso_oe, miso}, 8'h00);

        // R2: select drives the enable; R1 again after release.
        sel(1'b0);
        check8("R2", {7'd0, miso_oe}, 8'h01);
        desel(1'b0);
        check8("R1", {6'd0, miso_oe, miso}, 8'h00);

        // R4 / R9: start addresses across the space, both idle levels.
        for (int i = 0; i < 32; i++) begin
            do_read(1'b0, 16'(i * 16'h0811 + 3), 3, "R4");
            do_read(1'b1, 16'(i * 16'h0811 + 5), 3, "R9");
        end

        // R5: long stream past the array size.
        do_read(1'b0, 16'h1234, 70, "R5");

        // R6: wrap at the top of the address space, both modes.
        do_read(1'b0, 16'hFFFD, 5, "R6");
        do_read(1'b1, 16'hFFFF, 3, "R6");

        // R7: commands other than read.
        do_other(1'b0, 8'h0B);
        do_other(1'b1, 8'h83);
        do_other(1'b0, 8'h02);

        // R8: abort inside the address, then a clean read.
        sel(1'b0);
        xbyte(1'b0, 8'h03, r);
        for (int k = 0; k < 5; k++) xbit(1'b0, 1'b1, b);
        desel(1'b0);
        do_read(1'b0, 16'h0040, 2, "R8");
        sel(1'b1);
        for (int k = 0; k < 11; k++) xbit(1'b1, 1'b0, b);
        desel(1'b1);
        do_read(1'b1, 16'h0ABC, 2, "R8");

        // R10: bus activity while deselected has no effect.
        bad = 0;
        for (int k = 0; k < 24; k++) begin
            xbit(1'b0, (k % 3) == 0, b);
            if (miso_oe !== 1'b0 || miso !== 1'b0) bad++;
        end
        check8("R10", 8'(bad), 8'h00);
        do_read(1'b0, 16'h0007, 2, "R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule